// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block guards one stage of a producer/consumer data pipeline. It stays in its current phase until two things are both true. First, a programmed number of participants must have arrived. Second, every byte that those participants announced must have been reported as delivered by a copy engine. When both counters reach zero in the same cycle, the phase bit toggles. In that same step the barrier rearms itself for the next round of the pipeline.

Software first loads the expected arrival count with an init pulse. A participant signals a plain arrival, or an arrival that also announces a byte amount. The copy engine pulses a completion input with the number of bytes that have landed. A consumer presents the parity it waits for and reads `wait_ok`. That output is high once the phase bit has moved away from that parity. From then on the stage data is complete.

The controller has three states:
- `ST_UNINIT`: after reset, before any init.
- `ST_GATHER`: arrivals are still owed.
- `ST_DRAIN`: all arrivals are in, but bytes are still pending.

It has these transitions:
- Init: UNINIT or any armed state goes to GATHER.
- Last arrival with bytes outstanding: GATHER goes to DRAIN.
- Flip: GATHER or DRAIN goes to GATHER, with the phase toggled and the counters reloaded.
- Hold: the state stays as it is.

Top module: `txn_phase_barrier`

## Requirements
- R1: After reset, `phase` is 0, `err` is 0 and the barrier is uninitialised.
- R2: Before the first valid init, arrive, arrive-with-bytes and completion inputs have no effect on `phase` or `err`.
- R3: An init with a nonzero count sets the expected arrival count, clears the pending bytes and sets `phase` to 0, one edge later. In that cycle, init takes priority and the other inputs are dropped. An init with count 0 is ignored, while the other inputs of that cycle still apply.
- R4: A plain arrive removes one owed arrival. An arrive-with-bytes removes one owed arrival and adds `tx_bytes` to the pending count in the same cycle.
- R5: A completion pulse subtracts `done_bytes` from the pending count.
- R6: `phase` toggles on the edge that closes a cycle in which owed arrivals and pending bytes are both zero. It never toggles while pending bytes are nonzero.
- R7: An arrival and a completion in the same cycle are both applied before completion is evaluated.
- R8: On a toggle, the owed arrival count reloads to the init value and the pending count is zero. The next phase then needs the same number of arrivals, with no new init.
- R9: `err` is set by any of three faults: a completion larger than the pending bytes (pending clamps to 0), more arrivals than are owed (owed clamps to 0), or pending-count overflow. Once set, `err` stays high until reset, including through later inits.
- R10: `wait_ok` is combinationally `phase` XOR `wait_parity`.
- R11: A plain arrive and an arrive-with-bytes in the same cycle count as two arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load a new expected arrival count |
| init_count | input | CNT_W | Expected arrivals per phase |
| arrive | input | 1 | Plain arrival |
| arrive_tx | input | 1 | Arrival that also announces bytes |
| tx_bytes | input | BYTE_W | Bytes announced by `arrive_tx` |
| done_valid | input | 1 | Copy-engine delivery report |
| done_bytes | input | BYTE_W | Bytes delivered |
| wait_parity | input | 1 | Parity the waiter expects to leave |
| phase | output | 1 | Current phase bit |
| wait_ok | output | 1 | Phase differs from `wait_parity` |
| err | output | 1 | Sticky fault flag |

## Verification
`phase` and `err` are registered, so each is due on the first rising edge after the cycle that carried the stimulus. `wait_ok` follows `phase` and the current `wait_parity` within the same cycle. The bench applies each stimulus at a falling edge. One nanosecond after the next rising edge, it advances its own model of owed arrivals and pending bytes. At that same instant it compares all three outputs, so every result is checked in exactly the cycle it is due.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_GATHER = 2'd1,
        ST_DRAIN  = 2'd2
    } txb_state_e;
endpackage

// File: rtl/txb_arrival_ctr.sv
module txb_arrival_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic [1:0]       n_arr,
    input  logic             rearm,
    output logic [CNT_W-1:0] left_q,
    output logic [CNT_W-1:0] target_q,
    output logic             hits_zero,
    output logic             excess
);
    logic [CNT_W-1:0] n_ext;
    logic [CNT_W-1:0] left_nxt;
    logic             too_many;

    always_comb begin
        n_ext     = CNT_W'(n_arr);
        too_many  = (n_ext > left_q);
        excess    = en && too_many;
        left_nxt  = too_many ? '0 : (left_q - n_ext);
        hits_zero = (left_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q   <= '0;
            target_q <= '0;
        end else if (load) begin
            left_q   <= load_val;
            target_q <= load_val;
        end else if (rearm) begin
            left_q   <= target_q;
        end else if (en) begin
            left_q   <= left_nxt;
        end
    end

    // R4: no arrival and no load/rearm leaves the owed count untouched
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rearm && (!en || n_arr == 2'd0)) |=> $stable(left_q));

    // R11: two simultaneous arrivals remove two owed arrivals
    a_r11_double_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !rearm && n_arr == 2'd2 && left_q >= CNT_W'(2))
        |=> (left_q == $past(left_q) - CNT_W'(2)));
endmodule

// File: rtl/txb_byte_ctr.sv
module txb_byte_ctr #(
    parameter int BYTE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              en,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] add_val,
    input  logic              sub_en,
    input  logic [BYTE_W-1:0] sub_val,
    output logic [BYTE_W-1:0] pend_q,
    output logic              zero_nxt,
    output logic              underflow,
    output logic              overflow
);
    localparam int SUM_W = BYTE_W + 1;

    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  sub_ext;
    logic [SUM_W-1:0]  res;
    logic [BYTE_W-1:0] pend_nxt;
    logic              short;

    always_comb begin
        sum       = {1'b0, pend_q} + {1'b0, (add_en ? add_val : {BYTE_W{1'b0}})};
        sub_ext   = {1'b0, (sub_en ? sub_val : {BYTE_W{1'b0}})};
        short     = (sub_ext > sum);
        underflow = en && short;
        overflow  = en && sum[BYTE_W];
        res       = short ? {SUM_W{1'b0}} : (sum - sub_ext);
        pend_nxt  = res[BYTE_W-1:0];
        zero_nxt  = (pend_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= '0;
        end else if (en) begin
            pend_q <= pend_nxt;
        end
    end

    // R5: a lone delivery within budget subtracts exactly its byte amount
    a_r5_delivery_subtracts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && sub_en && !add_en && sub_val <= pend_q)
        |=> (pend_q == $past(pend_q) - $past(sub_val)));
endmodule

// File: rtl/txn_phase_barrier.sv
module txn_phase_barrier
    import txb_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int BYTE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [CNT_W-1:0]  init_count,
    input  logic              arrive,
    input  logic              arrive_tx,
    input  logic [BYTE_W-1:0] tx_bytes,
    input  logic              done_valid,
    input  logic [BYTE_W-1:0] done_bytes,
    input  logic              wait_parity,
    output logic              phase,
    output logic              wait_ok,
    output logic              err
);
    txb_state_e        state_q, state_d;
    logic              phase_q, err_q;
    logic              load_ok, armed, op_en, flip;
    logic [1:0]        n_arr;
    logic [CNT_W-1:0]  left_q, target_q;
    logic              hits_zero, excess;
    logic [BYTE_W-1:0] pend_q;
    logic              zero_nxt, underflow, overflow;

    always_comb begin
        load_ok = init_valid && (init_count != '0);
        armed   = (state_q != ST_UNINIT);
        op_en   = armed && !load_ok;
        n_arr   = {1'b0, arrive} + {1'b0, arrive_tx};
        flip    = op_en && hits_zero && zero_nxt;
    end

    txb_arrival_ctr #(.CNT_W(CNT_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .load_val  (init_count),
        .en        (op_en),
        .n_arr     (n_arr),
        .rearm     (flip),
        .left_q    (left_q),
        .target_q  (target_q),
        .hits_zero (hits_zero),
        .excess    (excess)
    );

    txb_byte_ctr #(.BYTE_W(BYTE_W)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .en        (op_en),
        .add_en    (arrive_tx),
        .add_val   (tx_bytes),
        .sub_en    (done_valid),
        .sub_val   (done_bytes),
        .pend_q    (pend_q),
        .zero_nxt  (zero_nxt),
        .underflow (underflow),
        .overflow  (overflow)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNINIT: state_d = load_ok ? ST_GATHER : ST_UNINIT;
            ST_GATHER,
            ST_DRAIN: begin
                if (load_ok || flip) state_d = ST_GATHER;
                else if (hits_zero)  state_d = ST_DRAIN;
                else                 state_d = ST_GATHER;
            end
            default:   state_d = ST_UNINIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    // phase bit and sticky fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (load_ok)   phase_q <= 1'b0;
            else if (flip) phase_q <= ~phase_q;
            if (op_en && (excess || underflow || overflow)) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        phase   = phase_q;
        wait_ok = phase_q ^ wait_parity;
        err     = err_q;
    end

    // R2: without a valid init the barrier stays uninitialised at phase 0
    a_r2_uninit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNINIT && !load_ok) |=> (state_q == ST_UNINIT && !phase_q));

    // R3: init loads the count, clears bytes and phase
    a_r3_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (!phase_q && pend_q == '0 && left_q == $past(init_count)
                     && state_q == ST_GATHER));

    // R6: with bytes pending and none delivered or added, the phase holds
    a_r6_no_early_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !done_valid && !arrive_tx && pend_q != '0) |=> $stable(phase_q));

    // R6: the drain state is only ever occupied while bytes are outstanding
    a_r6_drain_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (pend_q != '0));

    // R8: a flip reloads the owed arrivals and leaves no pending bytes
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (left_q == target_q && pend_q == '0));

    // R9: the fault flag never clears without reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/sim_txn_phase_barrier.sv
module sim_txn_phase_barrier;
    localparam int  CNT_W  = 10;
    localparam int  BYTE_W = 20;
    localparam longint BMAX = (64'd1 << BYTE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_valid = 1'b0;
    logic [CNT_W-1:0]  init_count = '0;
    logic              arrive = 1'b0;
    logic              arrive_tx = 1'b0;
    logic [BYTE_W-1:0] tx_bytes = '0;
    logic              done_valid = 1'b0;
    logic [BYTE_W-1:0] done_bytes = '0;
    logic              wait_parity = 1'b0;
    logic              phase, wait_ok, err;

    int errors = 0;
    int checks = 0;

    bit     m_armed;
    int     m_tgt, m_left;
    longint m_pend;
    bit     m_phase, m_err;

    always #2 clk = ~clk;

    txn_phase_barrier #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_count(init_count),
        .arrive(arrive), .arrive_tx(arrive_tx), .tx_bytes(tx_bytes),
        .done_valid(done_valid), .done_bytes(done_bytes), .wait_parity(wait_parity),
        .phase(phase), .wait_ok(wait_ok), .err(err)
    );

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input bit wp);
        check_bit(tag, "phase", phase, m_phase);
        check_bit(tag, "err", err, m_err);
        check_bit(tag, "wait_ok", wait_ok, m_phase ^ wp);
    endtask

    task automatic model(input bit iv, input int ic, input bit a, input bit at,
                         input int b, input bit dv, input int db);
        longint sum, sub;
        int n;
        if (iv && ic != 0) begin
            m_armed = 1; m_tgt = ic; m_left = ic; m_pend = 0; m_phase = 0;
        end else if (m_armed) begin
            n = int'(a) + int'(at);
            if (n > m_left) begin m_err = 1; m_left = 0; end
            else m_left = m_left - n;
            sum = m_pend + (at ? longint'(b) : 0);
            sub = dv ? longint'(db) : 0;
            if (sum > BMAX) m_err = 1;
            if (sub > sum) begin m_err = 1; m_pend = 0; end
            else m_pend = (sum - sub) & BMAX;
            if (m_left == 0 && m_pend == 0) begin
                m_phase = ~m_phase;
                m_left  = m_tgt;
            end
        end
    endtask

    task automatic step(input string tag, input bit iv, input int ic, input bit a,
                        input bit at, input int b, input bit dv, input int db, input bit wp);
        @(negedge clk);
        init_valid = iv; init_count = CNT_W'(ic);
        arrive = a; arrive_tx = at; tx_bytes = BYTE_W'(b);
        done_valid = dv; done_bytes = BYTE_W'(db); wait_parity = wp;
        @(posedge clk);
        #1;
        model(iv, ic, a, at, b, dv, db);
        compare(tag, wp);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        init_valid = 0; arrive = 0; arrive_tx = 0; done_valid = 0;
        repeat (2) @(negedge clk);
        m_armed = 0; m_tgt = 0; m_left = 0; m_pend = 0; m_phase = 0; m_err = 0;
        rst_n = 1'b1;
        wait_parity = 1'b1;
        #1;
        compare(tag, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset("R1");
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: stimulus before init is ignored
        step("R2", 0, 0, 1, 1, 8, 1, 4, 0);
        step("R2", 0, 0, 0, 0, 0, 1, 9, 1);
        // R3: init 1; arrive_tx of zero bytes completes immediately
        step("R3", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 1, 0, 0, 0, 0);
        // R3: count-zero init ignored, the arrival in that cycle still counts
        step("R3", 1, 0, 1, 0, 0, 0, 0, 1);
        // R3: init priority drops the same-cycle arrival
        step("R3", 1, 2, 1, 0, 0, 0, 0, 1);
        step("R3", 0, 0, 1, 0, 0, 0, 0, 1);
        step("R4", 0, 0, 1, 0, 0, 0, 0, 0);
        // R6: flip held until bytes drain
        step("R6", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 1, 32, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 1, 16, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R6", 0, 0, 0, 0, 0, 1, 16, 0);
        // R7: arrival and delivery in one cycle
        step("R7", 1, 2, 0, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 10, 1, 10, 1);
        // R11: two arrivals in one cycle
        step("R11", 0, 0, 1, 1, 0, 0, 0, 0);
        // R8: next phase rearmed with no init
        step("R8", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 1, 5, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 0, 1, 5, 0);
        // R9: underflow
        step("R9", 1, 1, 0, 1, 4, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 1, 5, 0);
        step("R9", 1, 3, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        do_reset("R1");
        // R9: excess arrival
        step("R9", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 1, 1, 8, 0, 0, 0);
        do_reset("R1");
        // R9: pending overflow
        step("R9", 1, 3, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, int'(BMAX), 0, 0, 0);
        step("R9", 0, 0, 0, 1, int'(BMAX), 0, 0, 0);
        do_reset("R1");
        step("R3", 1, 3, 0, 0, 0, 0, 0, 0);
        // constrained random legal traffic (R4 R5 R6 R7 R8 R10 R11)
        for (int i = 0; i < 4000; i++) begin
            bit iv, a, at, dv, wp;
            int ic, b, db;
            longint avail;
            iv = ($urandom % 300 == 0);
            ic = 1 + int'($urandom % 4);
            wp = $urandom % 2;
            a  = (m_left >= 1) && ($urandom % 3 == 0);
            at = (m_left >= (a ? 2 : 1)) && ($urandom % 3 == 0);
            b  = int'($urandom % 64);
            avail = m_pend + (at ? longint'(b) : 0);
            dv = (avail > 0) && ($urandom % 2 == 0);
            if (dv) db = ($urandom % 2 == 0) ? int'(avail) : 1 + int'($urandom % avail);
            else    db = 0;
            step("R6", iv, ic, a, at, b, dv, db, wp);
        end
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule